// File: doc/BRIEF.md
# Sleep and Clock-Stop Controller

This block sits beside an 8-bit microcontroller core and turns the core's sleep-instruction pulse into clock-stop requests for an external clock generator. It never gates a clock itself. Instead it raises one of three requests. The first halts only the core clock. The second halts the core clock and the peripheral clock together. The third drops a clock-enable line, which stops every clock except a free-running one. The block runs entirely on that free-running clock, so its wake-up detection keeps working while everything else is stopped.

Software picks the behaviour through an 8-bit control register. The register is mapped at a parameterised 6-bit I/O address and is accessed with I/O read and write strobes. A sleep pulse only has an effect when the register's enable bit is set. The selected mode is captured when sleep begins. The block returns to the running state when the core reports that an interrupt condition exists, or when reset is applied.

Top module: `slpctl_top`

## Requirements
- R1: After reset the control register reads 0x00 and the outputs are stop_core=0, stop_io=0, clk_en=1.
- R2: A write strobe with io_addr equal to the parameter REG_ADDR (default 6'h33) stores io_wdata on the next clock edge. A write to any other address leaves the register unchanged.
- R3: While io_rd is high and io_addr equals REG_ADDR, io_rdata shows the full stored byte in the same cycle. Otherwise io_rdata is 0x00.
- R4: Register bit 0 is the sleep enable and bits 2:1 are the mode. Mode 00 (idle) requests stop_core only. Mode 01 (power-save) requests stop_core and stop_io. Mode 10 (power-down) drives clk_en low with both stop lines low. Mode 11 behaves as idle. Bits 7:3 are stored and read back, and have no other effect.
- R5: A sleep_pulse sampled while the enable bit is 1 and wake_rdy is low enters sleep. The mode outputs appear one clock edge later.
- R6: A sleep_pulse sampled while the enable bit is 0 is ignored, and the outputs stay in the running state.
- R7: While asleep without wake_rdy, the outputs hold their values. Register writes made during sleep do not change them, because the mode is captured when sleep begins.
- R8: wake_rdy sampled high during sleep returns the outputs to the running state on the next clock edge.
- R9: A sleep_pulse that coincides with wake_rdy does not enter sleep. A wake_rdy seen while running has no effect.
- R10: Asserting reset during sleep releases all stop requests at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_pulse | input | 1 | Sleep-instruction pulse from the core |
| wake_rdy | input | 1 | Interrupt-condition indication from the core |
| io_addr | input | 6 | I/O address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (0 when not selected) |
| stop_core | output | 1 | Request to halt the core clock |
| stop_io | output | 1 | Request to halt the peripheral clock |
| clk_en | output | 1 | Clock enable; low stops all clocks but the free-running one |

## Verification
The assertions assume that sleep_pulse and wake_rdy are synchronous to the free-running clock and are single-valued at each edge. They also assume that the read strobe is only checked against the one mapped address. The bench drives every input on the falling edge, keeps sleep_pulse to a single cycle and never asserts the read and write strobes together. It samples the registered stop outputs one rising edge after the stimulus, which matches the single register stage between input and output.

// File: rtl/slpctl_pkg.sv
package slpctl_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_SAVE = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_RSVD = 2'b11
    } sleep_mode_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } slp_state_e;

    typedef struct packed {
        logic stop_core;
        logic stop_io;
        logic gate_all;
    } stop_req_t;

    function automatic stop_req_t mode_to_req(sleep_mode_e m);
        stop_req_t r;
        r = '0;
        case (m)
            MODE_SAVE: begin r.stop_core = 1'b1; r.stop_io = 1'b1; end
            MODE_DOWN: r.gate_all = 1'b1;
            default:   r.stop_core = 1'b1;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/slpctl_modereg.sv
module slpctl_modereg
    import slpctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              sleep_en,
    output sleep_mode_e       sleep_mode
);
    typedef struct packed {
        logic [DATA_W-1:0] value;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        hit  = (io_addr == REG_ADDR);
        st_d = st_q;
        if (io_wr && hit) begin
            st_d.value = io_wdata;
        end
        io_rdata = (io_rd && hit) ? st_q.value : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sleep_en   = st_q.value[0];
    assign sleep_mode = sleep_mode_e'(st_q.value[2:1]);
endmodule

// File: rtl/slpctl_fsm.sv
module slpctl_fsm
    import slpctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_pulse,
    input  logic        wake_rdy,
    input  logic        sleep_en,
    input  sleep_mode_e sleep_mode,
    output logic        stop_core,
    output logic        stop_io,
    output logic        clk_en
);
    typedef struct packed {
        slp_state_e state;
        stop_req_t  req;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            ST_RUN: begin
                if (sleep_pulse && sleep_en && !wake_rdy) begin
                    st_d.state = ST_SLEEP;
                    st_d.req   = mode_to_req(sleep_mode);
                end
            end
            ST_SLEEP: begin
                if (wake_rdy) begin
                    st_d.state = ST_RUN;
                    st_d.req   = '0;
                end
            end
            default: begin
                st_d.state = ST_RUN;
                st_d.req   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_RUN, req: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign stop_core = st_q.req.stop_core;
    assign stop_io   = st_q.req.stop_io;
    assign clk_en    = !st_q.req.gate_all;
endmodule

// File: rtl/slpctl_top.sv
module slpctl_top
    import slpctl_pkg::*;
#(
    parameter logic [5:0] REG_ADDR = 6'h33
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_pulse,
    input  logic       wake_rdy,
    input  logic [5:0] io_addr,
    input  logic       io_rd,
    input  logic       io_wr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    output logic       stop_core,
    output logic       stop_io,
    output logic       clk_en
);
    logic        sleep_en;
    sleep_mode_e sleep_mode;

    slpctl_modereg #(.REG_ADDR(REG_ADDR)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .sleep_en   (sleep_en),
        .sleep_mode (sleep_mode)
    );

    slpctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_pulse (sleep_pulse),
        .wake_rdy    (wake_rdy),
        .sleep_en    (sleep_en),
        .sleep_mode  (sleep_mode),
        .stop_core   (stop_core),
        .stop_io     (stop_io),
        .clk_en      (clk_en)
    );
endmodule

// File: rtl/slpctl_chk.sv
module slpctl_chk #(
    parameter logic [5:0] REG_ADDR = 6'h33
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_pulse,
    input logic       wake_rdy,
    input logic [5:0] io_addr,
    input logic       io_rd,
    input logic [7:0] io_rdata,
    input logic       stop_core,
    input logic       stop_io,
    input logic       clk_en
);
    logic running;
    assign running = clk_en && !stop_core && !stop_io;

    // R4
    io_stop_implies_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_io |-> stop_core);

    // R4
    powerdown_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (!stop_core && !stop_io));

    // R8
    wake_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_rdy && !running) |=> running);

    // R9
    no_entry_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (wake_rdy || !sleep_pulse)) |=> running);

    // R7
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wake_rdy) |=> ($stable(stop_core) && $stable(stop_io) && $stable(clk_en)));

    // R3
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_addr == REG_ADDR) |-> (io_rdata == 8'h00));
endmodule

bind slpctl_top slpctl_chk #(.REG_ADDR(REG_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_pulse (sleep_pulse),
    .wake_rdy    (wake_rdy),
    .io_addr     (io_addr),
    .io_rd       (io_rd),
    .io_rdata    (io_rdata),
    .stop_core   (stop_core),
    .stop_io     (stop_io),
    .clk_en      (clk_en)
);

// File: tb/slpctl_top_tb.sv
module slpctl_top_tb;
    localparam logic [5:0] ADDR = 6'h33;
    localparam logic [2:0] O_RUN  = 3'b001;
    localparam logic [2:0] O_IDLE = 3'b101;
    localparam logic [2:0] O_SAVE = 3'b111;
    localparam logic [2:0] O_DOWN = 3'b000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_pulse = 1'b0;
    logic       wake_rdy = 1'b0;
    logic [5:0] io_addr = '0;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       stop_core, stop_io, clk_en;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    slpctl_top #(.REG_ADDR(ADDR)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_pulse(sleep_pulse), .wake_rdy(wake_rdy),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .stop_core(stop_core), .stop_io(stop_io), .clk_en(clk_en)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] outs();
        return {stop_core, stop_io, clk_en};
    endfunction

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [5:0] a, logic [7:0] exp);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 check(req, io_rdata, exp);
        io_rd = 1'b0;
    endtask

    task automatic pulse_sleep(logic wake_too);
        @(negedge clk);
        sleep_pulse = 1'b1; wake_rdy = wake_too;
        @(negedge clk);
        sleep_pulse = 1'b0; wake_rdy = 1'b0;
    endtask

    task automatic wake();
        @(negedge clk);
        wake_rdy = 1'b1;
        @(negedge clk);
        wake_rdy = 1'b0;
    endtask

    task automatic t_reset();
        rd_check("R1 reg", ADDR, 8'h00);
        check("R1 outs", {5'b0, outs()}, {5'b0, O_RUN});
    endtask

    task automatic t_regio();
        wr(ADDR, 8'hA4);
        rd_check("R2 write", ADDR, 8'hA4);
        wr(6'h12, 8'h5B);
        rd_check("R2 other addr", ADDR, 8'hA4);
        rd_check("R3 wrong addr read", 6'h12, 8'h00);
        @(negedge clk);
        io_addr = ADDR; io_rd = 1'b0;
        #1 check("R3 no strobe", io_rdata, 8'h00);
    endtask

    task automatic t_mode(string req, logic [7:0] regv, logic [2:0] exp);
        wr(ADDR, regv);
        pulse_sleep(1'b0);
        check({req, " enter"}, {5'b0, outs()}, {5'b0, exp});
        repeat (3) @(negedge clk);
        check("R7 hold", {5'b0, outs()}, {5'b0, exp});
        wake();
        check("R8 wake", {5'b0, outs()}, {5'b0, O_RUN});
    endtask

    task automatic t_disabled();
        wr(ADDR, 8'h02);
        pulse_sleep(1'b0);
        check("R6 ignored", {5'b0, outs()}, {5'b0, O_RUN});
    endtask

    task automatic t_write_during_sleep();
        wr(ADDR, 8'h01);
        pulse_sleep(1'b0);
        wr(ADDR, 8'h05);
        check("R7 write in sleep", {5'b0, outs()}, {5'b0, O_IDLE});
        rd_check("R7 reg updated", ADDR, 8'h05);
        wake();
        check("R8 wake after write", {5'b0, outs()}, {5'b0, O_RUN});
    endtask

    task automatic t_coincide();
        wr(ADDR, 8'h03);
        pulse_sleep(1'b1);
        check("R9 coincident wake", {5'b0, outs()}, {5'b0, O_RUN});
        wake();
        check("R9 wake in run", {5'b0, outs()}, {5'b0, O_RUN});
    endtask

    task automatic t_reset_in_sleep();
        wr(ADDR, 8'h05);
        pulse_sleep(1'b0);
        check("R10 pre", {5'b0, outs()}, {5'b0, O_DOWN});
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R10 release", {5'b0, outs()}, {5'b0, O_RUN});
        @(negedge clk);
        rst_n = 1'b1;
        rd_check("R10 reg cleared", ADDR, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regio();
        t_mode("R5 R4 idle", 8'h01, O_IDLE);
        t_mode("R5 R4 save", 8'h03, O_SAVE);
        t_mode("R5 R4 down", 8'h05, O_DOWN);
        t_mode("R4 mode11", 8'hF7, O_IDLE);
        t_disabled();
        t_write_during_sleep();
        t_coincide();
        t_reset_in_sleep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule